// File: doc/BRIEF.md
# Hibernate Wakeup Filter and Reset Timer

This block sequences entry into and exit from hibernation in the always-on slow-clock domain. Software requests hibernation with a register write, and the block then raises a power-down output. While it hibernates, it watches an active-low wakeup pin. It accepts a wakeup only after the pin has stayed low for a programmed number of slow-clock ticks, so shorter pulses and glitches are rejected.

Once a wakeup is accepted, the power-down output drops. A reset output is then held low for a second programmed number of ticks. After that the block returns to normal running.

Both durations are programmed through registers that keep only their upper bits. Every duration is therefore a whole multiple of 32 ticks. The wakeup pin passes through a two-flop synchronizer before it is filtered.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, `pwr_down` is 0 and `rst_out_n` is 1. The filter register (address 1) and the reset-length register (address 2) both read as 0.
- R2: The hibernate register is at address 0. While running, a write to it with data bit 0 set makes `pwr_down` read 1 from the next cycle. A write to it with bit 0 clear has no effect. Reading address 0 returns `pwr_down` in bit 0 and zeros in all other bits.
- R3: The filter register (address 1) stores data bits 15:5. Bits 4:0 are ignored on write and read back as zero.
- R4: The reset-length register (address 2) stores data bits 11:5. All other bits are ignored on write and read back as zero.
- R5: Call F the filter register's read value. The wakeup pin is sampled by a two-flop synchronizer. When the pin goes low before clock edge k and stays low, `pwr_down` falls after edge k+2+F.
- R6: A low pulse on the wakeup pin that is shorter than the filter time is ignored, and it restarts the filter count. A later sustained low then needs the full F+3 edges.
- R7: A filter value of 0 accepts a wakeup on the first synchronized low sample, 3 edges after the pin falls.
- R8: Call R the reset-length register's read value. After an accepted wakeup, `rst_out_n` is low for exactly R cycles and then goes high. When R is 0, no reset pulse occurs.
- R9: The wakeup pin has no effect while the block is running.
- R10: `pwr_down` high and `rst_out_n` low never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 hibernate, 1 filter, 2 reset length |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| wake_n | input | 1 | Active-low wakeup pin, asynchronous |
| pwr_down | output | 1 | High while hibernating |
| rst_out_n | output | 1 | Active-low reset pulse after wakeup |

## Verification
The assertions check the following on every cycle:
- The power-down and reset outputs never overlap.
- A hibernate request while running always takes effect.
- The block never leaves the running state without a request.
- A reset pulse only follows hibernation.
- An exit from hibernation is preceded by a low synchronized wakeup sample.
- The ignored register bits always read as zero.

Only the bench scenarios can show the exact latency of F+3 edges, the exact reset-pulse length of R cycles, and the restart of the filter after a glitch. These checks need a known stimulus history and counted windows.

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int DW  = 16,
  parameter int LSB = 5,
  parameter int FW  = 11,
  parameter int RW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wake_n,
  output logic          pwr_down,
  output logic          rst_out_n
);
  localparam int RPAD = DW - RW - LSB;

  typedef enum logic [1:0] {S_RUN, S_HIB, S_RST} st_t;

  st_t           st_q;
  logic [FW-1:0] filt_q;
  logic [RW-1:0] rlen_q;
  logic [1:0]    sync_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] filt_len, rlen;
  logic          wake_seen, hib_req;

  assign wake_seen = !sync_q[1];
  assign filt_len  = DW'({filt_q, {LSB{1'b0}}});
  assign rlen      = DW'({rlen_q, {LSB{1'b0}}});
  assign hib_req   = wr_en && (wr_addr == 2'd0) && wr_data[0];
  assign pwr_down  = (st_q == S_HIB);
  assign rst_out_n = (st_q != S_RST);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = DW'(pwr_down);
      2'd1:    rd_data = filt_len;
      2'd2:    rd_data = rlen;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], wake_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      rlen_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd1) filt_q <= wr_data[LSB+FW-1:LSB];
      if (wr_addr == 2'd2) rlen_q <= wr_data[LSB+RW-1:LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_RUN: begin
          cnt_q <= '0;
          if (hib_req) st_q <= S_HIB;
        end
        S_HIB: begin
          if (!wake_seen) cnt_q <= '0;
          else if (cnt_q == filt_len) begin
            cnt_q <= '0;
            st_q  <= (rlen == '0) ? S_RUN : S_RST;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_RST: begin
          if (cnt_q == rlen - 1'b1) begin
            cnt_q <= '0;
            st_q  <= S_RUN;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          cnt_q <= '0;
          st_q  <= S_RUN;
        end
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{RPAD[0]};
endmodule

// File: rtl/hib_wake_seq_chk.sv
module hib_wake_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          wake_n,
  input logic          pwr_down,
  input logic          rst_out_n
);
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_down && !rst_out_n));

  p_enter_hib_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[0] && !pwr_down && rst_out_n) |=> pwr_down);

  p_run_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && rst_out_n && !(wr_en && wr_addr == 2'd0 && wr_data[0])) |=> (!pwr_down && rst_out_n));

  p_rst_follows_hib_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(pwr_down));

  p_wake_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !$past(wake_n, 3));

  p_filt_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (rd_data[4:0] == 5'd0));

  p_rlen_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd2) |-> (rd_data[4:0] == 5'd0 && rd_data[DW-1:12] == '0));
endmodule

bind hib_wake_seq hib_wake_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .wake_n(wake_n),
  .pwr_down(pwr_down), .rst_out_n(rst_out_n)
);

// File: tb/hib_wake_seq_tb.sv
module hib_wake_seq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [1:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic        wake_n = 1;
  logic        pwr_down, rst_out_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hib_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake_n(wake_n),
    .pwr_down(pwr_down), .rst_out_n(rst_out_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    int v;
    chk(pwr_down == 0, "R1 pwr_down", pwr_down, 0);
    chk(rst_out_n == 1, "R1 rst_out_n", rst_out_n, 1);
    rd(2'd1, v); chk(v == 0, "R1 filter reg", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 reset reg", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(2'd1, 16'hFFFF); rd(2'd1, v); chk(v == 16'hFFE0, "R3 filter bits", v, 16'hFFE0);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); chk(v == 16'h0FE0, "R4 reset bits", v, 16'h0FE0);
    wr(2'd0, 16'hFFFE); chk(pwr_down == 0, "R2 write zero ignored", pwr_down, 0);
    rd(2'd0, v); chk(v == 0, "R2 hib readback", v, 0);
  endtask

  task automatic t_run_ignores_pin();
    wake_n = 0; idle(10);
    chk(pwr_down == 0 && rst_out_n == 1, "R9 pin ignored when running", {pwr_down, rst_out_n}, 1);
    wake_n = 1; idle(4);
  endtask

  task automatic t_wake(input logic [15:0] fw, input logic [15:0] rw, input int f, input int r,
                        input int glitch, input string tag);
    int n, m, v;
    wr(2'd1, fw); wr(2'd2, rw);
    wr(2'd0, 16'h0001);
    chk(pwr_down == 1, "R2 enter hibernate", pwr_down, 1);
    rd(2'd0, v); chk(v == 1, "R2 hib readback", v, 1);
    if (glitch > 0) begin
      wake_n = 0; idle(glitch); wake_n = 1; idle(f + 10);
      chk(pwr_down == 1, "R6 glitch ignored", pwr_down, 1);
    end
    wake_n = 0; n = 0;
    while (n < 5000) begin
      @(posedge clk); n++; @(negedge clk);
      if (!pwr_down) break;
    end
    chk(n == f + 3, tag, n, f + 3);
    m = 0;
    while (!rst_out_n && m < 5000) begin m++; @(negedge clk); end
    chk(m == r, "R8 reset pulse length", m, r);
    wake_n = 1; idle(4);
    chk(pwr_down == 0 && rst_out_n == 1, "R8 back to running", {pwr_down, rst_out_n}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_regs();
    t_run_ignores_pin();
    t_wake(16'h003F, 16'h0040, 32, 64, 0, "R5 filter latency F=32");
    t_wake(16'h0000, 16'h0020, 0, 32, 0, "R7 zero filter latency");
    t_wake(16'h0040, 16'h0000, 64, 0, 0, "R5 filter latency F=64, R=0");
    t_wake(16'h0040, 16'h0020, 64, 32, 40, "R6 restart after glitch");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule